// File: doc/BRIEF.md
# Wide-Word Flash Prefetch Buffer

This block sits between a processor's byte-fetch port and a slow flash array that delivers a whole multi-byte word per read. It holds one aligned word together with its word address and a valid flag. A byte request whose word address matches the held word is answered in the same cycle from the buffer. Any other request starts a wide flash read. That read takes a fixed number of clock cycles, counted out by the block itself. When it ends, the block returns the requested byte and keeps the whole word for the fetches that follow.

Sequential code fetches therefore pay the flash latency once per word and are then served from the buffer for the remaining byte lanes. A jump to a different word pays the full latency again. An invalidate input empties the buffer, for example after the flash contents have changed. One-cycle hit and miss pulses let the surrounding logic count how the buffer behaves.

The processor raises `cpu_req` with `cpu_addr` and holds both until `cpu_rdy` is high. The byte on `cpu_data` is valid in that cycle.

Top module: `wordfetch_prefetch`

## Requirements
- R1: Out of reset the buffer holds no valid word. `cpu_rdy`, `fl_rd`, `hit_pulse` and `miss_pulse` are low, and the first request is a miss.
- R2: A request whose word address (`cpu_addr` without its low log2(LANES) bits) equals the held word's address while the buffer is valid raises `cpu_rdy` and `hit_pulse` in the same cycle and performs no flash read.
- R3: A request that is not a hit raises `miss_pulse` in its first cycle with `cpu_rdy` low. `fl_rd` is then high for exactly FLASH_LAT cycles, with `fl_addr` equal to the request's word address throughout. `cpu_rdy` rises in the last of those cycles.
- R4: After a miss completes, requests for any byte lane of the same word are hits until another miss or an invalidate.
- R5: Byte lane k of a flash word is `fl_rdata[k*BYTE_W +: BYTE_W]`, and the low log2(LANES) address bits select k. The same rule applies on the hit path and on the fill path.
- R6: A request to a different word is a miss even when the previous requests were hits, and it replaces the held word.
- R7: Asserting `flush` for one cycle while no fill is pending empties the buffer, so the next request misses. A hit served in the same cycle as `flush` is still delivered.
- R8: A `flush` seen in any cycle of a miss, including its first and last cycle, still delivers the requested byte but leaves the buffer empty afterwards.
- R9: `hit_pulse` and `miss_pulse` are never high together, and each request produces exactly one of them, in its first cycle only.
- R10: With no request pending and no fill in progress, `fl_rd` and `cpu_rdy` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Byte fetch request, held until ready |
| cpu_addr | input | ADDR_W (16) | Byte address of the fetch |
| cpu_rdy | output | 1 | Fetch completes this cycle |
| cpu_data | output | BYTE_W (8) | Fetched byte, valid with `cpu_rdy` |
| flush | input | 1 | Invalidate the held word |
| fl_rd | output | 1 | Wide flash read in progress |
| fl_addr | output | ADDR_W-log2(LANES) (14) | Word address of the flash read |
| fl_rdata | input | LANES*BYTE_W (32) | Wide word returned by flash |
| hit_pulse | output | 1 | One-cycle pulse for a buffer hit |
| miss_pulse | output | 1 | One-cycle pulse for a buffer miss |

## Verification
The bench builds the block with an 8-bit address, four byte lanes and a flash latency of three cycles. With an 8-bit address, every byte of the address space can be fetched in an ascending sweep, and a strided pattern and a descending pattern can each be run across the whole space. The flash model returns a byte computed arithmetically from its address, so every lane of every word has a known value. The short latency keeps each miss window small enough to inject an invalidate in each of its cycles.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
   typedef enum logic {
      PF_IDLE = 1'b0,
      PF_FILL = 1'b1
   } pf_state_e;
endpackage

// File: rtl/pfb_tag_cmp.sv
module pfb_tag_cmp #(
   parameter int TAG_W = 14
) (
   input  logic             valid,
   input  logic [TAG_W-1:0] held,
   input  logic [TAG_W-1:0] probe,
   output logic             match
);
   assign match = valid && (held == probe);
endmodule

// File: rtl/pfb_lane_sel.sv
module pfb_lane_sel #(
   parameter int LANES  = 4,
   parameter int BYTE_W = 8,
   parameter int SEL_W  = $clog2(LANES)
) (
   input  logic [LANES*BYTE_W-1:0] line,
   input  logic [SEL_W-1:0]        sel,
   output logic [BYTE_W-1:0]       q
);
   logic [BYTE_W-1:0] lanes [LANES];

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         assign lanes[k] = line[k*BYTE_W +: BYTE_W];
      end
   endgenerate

   assign q = lanes[sel];
endmodule

// File: rtl/pfb_wait_timer.sv
module pfb_wait_timer #(
   parameter int LAT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic busy,
   output logic done
);
   localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= CW'(LAT - 1);
      end else if (busy && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = busy && (cnt_q == '0);
endmodule

// File: rtl/wordfetch_prefetch.sv
module wordfetch_prefetch
   import pfb_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int LANES     = 4,
   parameter int BYTE_W    = 8,
   parameter int FLASH_LAT = 3
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                cpu_req,
   input  logic [ADDR_W-1:0]                   cpu_addr,
   output logic                                cpu_rdy,
   output logic [BYTE_W-1:0]                   cpu_data,
   input  logic                                flush,
   output logic                                fl_rd,
   output logic [ADDR_W-$clog2(LANES)-1:0]     fl_addr,
   input  logic [LANES*BYTE_W-1:0]             fl_rdata,
   output logic                                hit_pulse,
   output logic                                miss_pulse
);
   localparam int SEL_W    = $clog2(LANES);
   localparam int WORD_A_W = ADDR_W - SEL_W;
   localparam int LINE_W   = LANES * BYTE_W;

   generate
      if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("LANES must be a power of two, at least 2");
      end
      if (FLASH_LAT < 1) begin : g_bad_lat
         $error("FLASH_LAT must be at least 1");
      end
      if (ADDR_W <= SEL_W) begin : g_bad_addr
         $error("ADDR_W must exceed the lane select width");
      end
   endgenerate

   pf_state_e             state_q;
   logic [LINE_W-1:0]     line_q;
   logic [WORD_A_W-1:0]   tag_q;
   logic                  valid_q;
   logic                  drop_q;
   logic [WORD_A_W-1:0]   pend_word_q;
   logic [SEL_W-1:0]      pend_sel_q;

   logic [WORD_A_W-1:0]   word_in;
   logic [SEL_W-1:0]      sel_in;
   logic                  match;
   logic                  idle;
   logic                  fill_done;
   logic [BYTE_W-1:0]     hit_byte;
   logic [BYTE_W-1:0]     fill_byte;

   assign word_in = cpu_addr[ADDR_W-1:SEL_W];
   assign sel_in  = cpu_addr[SEL_W-1:0];
   assign idle    = (state_q == PF_IDLE);

   pfb_tag_cmp #(.TAG_W(WORD_A_W)) u_tag (
      .valid (valid_q),
      .held  (tag_q),
      .probe (word_in),
      .match (match)
   );

   pfb_lane_sel #(.LANES(LANES), .BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_hit_sel (
      .line (line_q),
      .sel  (sel_in),
      .q    (hit_byte)
   );

   pfb_lane_sel #(.LANES(LANES), .BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_fill_sel (
      .line (fl_rdata),
      .sel  (pend_sel_q),
      .q    (fill_byte)
   );

   pfb_wait_timer #(.LAT(FLASH_LAT)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (miss_pulse),
      .busy  (state_q == PF_FILL),
      .done  (fill_done)
   );

   assign hit_pulse  = idle && cpu_req && match;
   assign miss_pulse = idle && cpu_req && !match;
   assign cpu_rdy    = hit_pulse || fill_done;
   assign cpu_data   = fill_done ? fill_byte : hit_byte;
   assign fl_rd      = (state_q == PF_FILL);
   assign fl_addr    = pend_word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= PF_IDLE;
         pend_word_q <= '0;
         pend_sel_q  <= '0;
         drop_q      <= 1'b0;
      end else begin
         case (state_q)
            PF_IDLE: begin
               if (miss_pulse) begin
                  state_q     <= PF_FILL;
                  pend_word_q <= word_in;
                  pend_sel_q  <= sel_in;
                  drop_q      <= flush;
               end
            end
            PF_FILL: begin
               if (flush) drop_q <= 1'b1;
               if (fill_done) state_q <= PF_IDLE;
            end
            default: state_q <= PF_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         tag_q   <= '0;
         line_q  <= '0;
      end else if (fill_done) begin
         line_q  <= fl_rdata;
         tag_q   <= pend_word_q;
         valid_q <= !(drop_q || flush);
      end else if (flush) begin
         valid_q <= 1'b0;
      end
   end

   assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_pulse && miss_pulse));

   assert_hit_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit_pulse |-> cpu_rdy);

   assert_miss_starts_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      miss_pulse |=> fl_rd);

   assert_miss_not_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      miss_pulse |-> !cpu_rdy);

   assert_fill_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rdy && !hit_pulse) |-> fl_rd);

   assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_rd && $past(fl_rd)) |-> $stable(fl_addr));

   assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !hit_pulse);

   assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_req && !fl_rd) |-> !cpu_rdy);
endmodule

// File: tb/wordfetch_prefetch_bench.sv
module wordfetch_prefetch_bench;
   localparam int PERIOD = 10;
   localparam int AW     = 8;
   localparam int LN     = 4;
   localparam int BW     = 8;
   localparam int LAT    = 3;
   localparam int WAW    = AW - 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cpu_req = 1'b0;
   logic [AW-1:0]  cpu_addr = '0;
   logic           cpu_rdy;
   logic [BW-1:0]  cpu_data;
   logic           flush = 1'b0;
   logic           fl_rd;
   logic [WAW-1:0] fl_addr;
   logic [LN*BW-1:0] fl_rdata;
   logic           hit_pulse;
   logic           miss_pulse;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  m_valid = 1'b0;
   int  m_tag = 0;
   bit  finished = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   function automatic int flash_byte(input int a);
      return (a * 37 + 11) & 255;
   endfunction

   always_comb begin
      for (int k = 0; k < LN; k++)
         fl_rdata[k*BW +: BW] = 8'(flash_byte(int'(fl_addr) * 4 + k));
   end

   wordfetch_prefetch #(.ADDR_W(AW), .LANES(LN), .BYTE_W(BW), .FLASH_LAT(LAT)) u_wordfetch_prefetch (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
      .cpu_rdy(cpu_rdy), .cpu_data(cpu_data), .flush(flush), .fl_rd(fl_rd),
      .fl_addr(fl_addr), .fl_rdata(fl_rdata), .hit_pulse(hit_pulse),
      .miss_pulse(miss_pulse)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // one fetch; flush_at selects the cycle of the request in which flush is high (-1 none)
   task automatic fetch(input int a, input int flush_at);
      bit exp_hit;
      bit got;
      int waits;
      exp_hit = m_valid && (m_tag == (a >> 2));
      got = 1'b0;
      waits = 0;
      @(negedge clk);
      cpu_req  = 1'b1;
      cpu_addr = AW'(a);
      while (!got && waits < 50) begin
         flush = (waits == flush_at);
         #1;
         chk("R9", "pulse exclusive", int'(hit_pulse && miss_pulse), 0);
         if (waits == 0) begin
            chk("R2", "hit pulse", int'(hit_pulse), int'(exp_hit));
            chk("R3", "miss pulse", int'(miss_pulse), int'(!exp_hit));
            if (exp_hit) chk("R2", "no flash read on hit", int'(fl_rd), 0);
         end else begin
            chk("R9", "pulses quiet in wait", int'(hit_pulse || miss_pulse), 0);
            chk("R3", "flash read high", int'(fl_rd), 1);
            chk("R3", "flash word address", int'(fl_addr), a >> 2);
         end
         if (cpu_rdy) begin
            got = 1'b1;
            chk("R5", "fetched byte", int'(cpu_data), flash_byte(a));
         end
         @(negedge clk);
         if (!got) waits++;
      end
      cpu_req = 1'b0;
      flush   = 1'b0;
      chk("R3", "wait cycles", waits, exp_hit ? 0 : LAT);
      if (flush_at >= 0 && flush_at <= waits) begin
         m_valid = 1'b0;
      end else if (!exp_hit) begin
         m_valid = 1'b1;
         m_tag   = a >> 2;
      end
   endtask

   task automatic idle_check();
      @(negedge clk);
      #1;
      chk("R10", "idle flash read", int'(fl_rd), 0);
      chk("R10", "idle ready", int'(cpu_rdy), 0);
   endtask

   task automatic flush_pulse();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      m_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R1", "reset ready", int'(cpu_rdy), 0);
      chk("R1", "reset flash read", int'(fl_rd), 0);
      chk("R1", "reset pulses", int'(hit_pulse || miss_pulse), 0);
      rst_n = 1'b1;
      idle_check();

      // R1 R4 R5: ascending sweep over the whole space
      for (int a = 0; a < 256; a++) fetch(a, -1);
      idle_check();

      // R6: strided pattern crossing words
      for (int i = 0; i < 64; i++) fetch((i * 13 + 5) & 255, -1);

      // R4 R6: descending sweep
      for (int i = 0; i < 256; i += 3) fetch(255 - i, -1);
      idle_check();

      // R7: invalidate while idle, and on a hit cycle
      fetch(40, -1);
      fetch(41, -1);
      flush_pulse();
      fetch(42, -1);
      fetch(43, 0);
      fetch(40, -1);

      // R8: invalidate in each cycle of a miss
      for (int c = 0; c <= LAT; c++) begin
         fetch(100 + c * 8, -1);
         fetch(200 + c * 4, c);
         fetch(201 + c * 4, -1);
         fetch(202 + c * 4, -1);
      end
      idle_check();

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(PERIOD * 200000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule